// File: doc/BRIEF.md
# KCS Host Interface Controller

This block is the host-side end of a byte-wide management channel in the keyboard-controller style. A host bus port sees two byte registers: a data register at offset 0 and a command/status register at offset 1. Through a fixed handshake the host starts a request, writes its bytes, marks the final byte and then pulls the reply out one byte at a time. The block holds the request and reply in two small buffers and keeps the transfer state inside the status byte. It passes each complete request to a management back end over a valid/ready stream, stamped with a sequence tag. It takes the reply back over a second stream and discards any reply whose tag is stale.

Errors are reported in-band. An abort, a handshake byte that is not the read code, or a command that does not fit the current state puts the block into an error phase. The host then reads a one-byte error code through the normal read handshake. A single level interrupt output combines a pending output-full event and a pending attention event from the back end. Both events are gated by an enable input.

Back-pressure rules: on the request stream, `req_valid` stays high and `req_data`, `req_last`, `req_tag` and `req_len` stay stable until `req_ready` is seen high. On the response stream, a beat is taken in every cycle in which `rsp_valid` and `rsp_ready` are both high. `rsp_ready` is low only in the single cycle after a reply's last beat. All beats of one reply carry the same tag. The buffer capacity must be at least 4.

Top module: `kcs_host_if`

## Requirements
- R1: After reset the status byte reads 0x00, `irq` is low, `req_valid` is low and the sequence tag is 0.
- R2: The status byte holds the state in bits 7:6 (0 idle, 1 read, 2 write, 3 error). Bit 3 is command/data, bit 2 is attention, bit 1 is input-full and bit 0 is output-full. A host read at offset 1 returns the status byte and a host read at offset 0 returns the data-out byte.
- R3: A host write that is accepted sets input-full. A host write while input-full is set is ignored and changes no state. Input-full clears one cycle after acceptance, once the byte has been processed. The exception is the final request byte.
- R4: The command/data bit becomes 1 on an accepted write to offset 1 and 0 on an accepted write to offset 0.
- R5: In idle, command 0x61 enters the write state, clears the request length and sets output-full. Each data byte in the write state is appended. Bytes beyond the capacity are not stored but still counted in `req_len`, which saturates at its maximum.
- R6: After command 0x62, the next data byte is the final one. The stored bytes are then streamed on the request port with the current tag and `req_len`, `req_last` marks the final beat, and input-full stays set until the reply is taken in.
- R7: Reply beats whose tag differs from the current tag are dropped. A matching reply increments the tag, enters the read state, places the first reply byte in data-out, sets output-full and clears input-full.
- R8: A reply longer than the capacity is returned as its first two bytes followed by the completion code 0xCA, so its length is 3.
- R9: In the read state, writing 0x68 to offset 0 loads the next reply byte and sets output-full. Once all bytes have been read, the same write enters idle and sets output-full.
- R10: In the read state, any other data value enters the error state with error byte 0x02. In the error state, any data write enters the read state and presents the error byte.
- R11: Command 0x60 in any state but error increments the tag, loads error byte 0x01, enters the error state and sets output-full. In the error state, 0x60 has no effect.
- R12: A command that does not fit the state enters the error state with error byte 0x02. This applies to any command but 0x61 in idle, any command but 0x62 in write, and any command but 0x60 in read or error. Output-full is set except when the command arrives in idle or error.
- R13: `irq` is high while an output-full event or an attention event is pending; a pending flag is taken only while `irq_en` is high. A data read clears the output-full flag. A status read clears the attention flag but not status bit 2. `attn_set` sets status bit 2 and `attn_clr` clears the bit and its pending flag.
- R14: A host read at offset 0 clears output-full, unless the block sets output-full in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 1 | Register offset: 0 data, 1 command/status |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte (data-out or status) |
| irq_en | input | 1 | Interrupt enable |
| attn_set | input | 1 | Back end raises attention |
| attn_clr | input | 1 | Back end drops attention |
| irq | output | 1 | Level interrupt |
| req_valid | output | 1 | Request beat valid |
| req_ready | input | 1 | Request beat taken |
| req_data | output | 8 | Request byte |
| req_last | output | 1 | Final request beat |
| req_tag | output | TAG_W | Sequence tag of the request |
| req_len | output | LEN_W | Byte count written by host (saturating) |
| rsp_valid | input | 1 | Reply beat valid |
| rsp_ready | output | 1 | Reply beat accepted |
| rsp_data | input | 8 | Reply byte |
| rsp_last | input | 1 | Final reply beat |
| rsp_tag | input | TAG_W | Tag carried by the reply |

## Verification
The properties assume the host uses its strobes one at a time and drives a write only as a single-cycle pulse. They also assume the back end keeps a constant tag across the beats of one reply and does not start a new reply until the previous one has been taken. The stimulus meets these assumptions by construction. Host accesses come from blocking tasks that raise one strobe for exactly one cycle. Replies come from one task that holds a single tag across all its beats and always ends on a last beat. The randomized part varies request and reply lengths across the capacity boundary, ready stalls and stale-tag replies, but keeps to those framing rules.

// File: rtl/kcs_pkg.sv
package kcs_pkg;
  typedef enum logic [1:0] {
    KS_IDLE  = 2'd0,
    KS_READ  = 2'd1,
    KS_WRITE = 2'd2,
    KS_ERROR = 2'd3
  } kcs_state_e;

  typedef enum logic [1:0] {
    PH_HOST,
    PH_SEND,
    PH_WAIT,
    PH_COMMIT
  } kcs_phase_e;

  localparam logic [7:0] OP_ABORT  = 8'h60;
  localparam logic [7:0] OP_WSTART = 8'h61;
  localparam logic [7:0] OP_WEND   = 8'h62;
  localparam logic [7:0] OP_RDNEXT = 8'h68;

  localparam logic [7:0] EC_ABORTED = 8'h01;
  localparam logic [7:0] EC_BADOP   = 8'h02;
endpackage

// File: rtl/kcs_byte_ram.sv
module kcs_byte_ram #(
  parameter int DEPTH = 32,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/kcs_irq.sv
module kcs_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic obf_evt,
  input  logic data_rd,
  input  logic stat_rd,
  input  logic atn_evt,
  input  logic atn_off,
  output logic irq
);
  logic obf_pend_q, atn_pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      obf_pend_q <= 1'b0;
      atn_pend_q <= 1'b0;
    end else begin
      if (obf_evt && en)  obf_pend_q <= 1'b1;
      else if (data_rd)   obf_pend_q <= 1'b0;

      if (atn_off)             atn_pend_q <= 1'b0;
      else if (atn_evt && en)  atn_pend_q <= 1'b1;
      else if (stat_rd)        atn_pend_q <= 1'b0;
    end
  end

  assign irq = obf_pend_q | atn_pend_q;
endmodule

// File: rtl/kcs_host_if.sv
module kcs_host_if
  import kcs_pkg::*;
#(
  parameter int         CAP      = 32,
  parameter int         TAG_W    = 8,
  parameter int         LEN_W    = 8,
  parameter logic [7:0] TRUNC_CC = 8'hCA
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic             host_addr,
  input  logic [7:0]       host_wdata,
  output logic [7:0]       host_rdata,
  input  logic             irq_en,
  input  logic             attn_set,
  input  logic             attn_clr,
  output logic             irq,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [7:0]       req_data,
  output logic             req_last,
  output logic [TAG_W-1:0] req_tag,
  output logic [LEN_W-1:0] req_len,
  input  logic             rsp_valid,
  output logic             rsp_ready,
  input  logic [7:0]       rsp_data,
  input  logic             rsp_last,
  input  logic [TAG_W-1:0] rsp_tag
);
  localparam int AW = (CAP > 1) ? $clog2(CAP) : 1;
  localparam int CW = $clog2(CAP + 1);
  localparam logic [LEN_W-1:0] LEN_MAX = '1;
  localparam logic [LEN_W-1:0] CAP_L   = LEN_W'(CAP);

  kcs_state_e       st_q, st_d;
  kcs_phase_e       ph_q, ph_d;
  logic             obf_q, obf_d, ibf_q, ibf_d, cd_q, cd_d, atn_q, atn_d;
  logic             pend_q, pend_d, hcmd_q, hcmd_d, wend_q, wend_d;
  logic [7:0]       hold_q, hold_d, dout_q, dout_d;
  logic [LEN_W-1:0] icnt_q, icnt_d, rcnt_q, rcnt_d;
  logic [CW-1:0]    olen_q, olen_d, opos_q, opos_d;
  logic [AW-1:0]    sidx_q, sidx_d;
  logic [TAG_W-1:0] tag_q, tag_d;

  logic             wr_acc, obf_set;
  logic             rq_we, rs_we;
  logic [AW-1:0]    rs_waddr;
  logic [7:0]       rs_wdata, rs_rdata;
  logic [LEN_W-1:0] stored;
  logic [LEN_W:0]   rtotal;
  logic [7:0]       status_w;

  kcs_byte_ram #(.DEPTH(CAP)) u_reqbuf (
    .clk(clk), .we(rq_we), .waddr(icnt_q[AW-1:0]), .wdata(hold_q),
    .raddr(sidx_q), .rdata(req_data)
  );

  kcs_byte_ram #(.DEPTH(CAP)) u_rspbuf (
    .clk(clk), .we(rs_we), .waddr(rs_waddr), .wdata(rs_wdata),
    .raddr(opos_q[AW-1:0]), .rdata(rs_rdata)
  );

  kcs_irq u_irq (
    .clk(clk), .rst_n(rst_n), .en(irq_en), .obf_evt(obf_set),
    .data_rd(host_rd && !host_addr), .stat_rd(host_rd && host_addr),
    .atn_evt(attn_set), .atn_off(attn_clr), .irq(irq)
  );

  assign status_w   = {st_q, 2'b00, cd_q, atn_q, ibf_q, obf_q};
  assign host_rdata = host_addr ? status_w : dout_q;
  assign wr_acc     = host_wr && !ibf_q;
  assign stored     = (icnt_q < CAP_L) ? icnt_q : CAP_L;
  assign req_valid  = (ph_q == PH_SEND);
  assign req_last   = (LEN_W'(sidx_q) == stored - 1'b1);
  assign req_tag    = tag_q;
  assign req_len    = icnt_q;
  assign rsp_ready  = (ph_q != PH_COMMIT);
  assign rtotal     = {1'b0, rcnt_q} + 1'b1;

  always_comb begin
    st_d = st_q;   ph_d = ph_q;   obf_d = obf_q; ibf_d = ibf_q;
    cd_d = cd_q;   atn_d = atn_q; pend_d = pend_q; hcmd_d = hcmd_q;
    wend_d = wend_q; hold_d = hold_q; dout_d = dout_q;
    icnt_d = icnt_q; rcnt_d = rcnt_q; olen_d = olen_q; opos_d = opos_q;
    sidx_d = sidx_q; tag_d = tag_q;
    obf_set = 1'b0; rq_we = 1'b0; rs_we = 1'b0;
    rs_waddr = '0;  rs_wdata = EC_BADOP;

    if (attn_clr)      atn_d = 1'b0;
    else if (attn_set) atn_d = 1'b1;

    if (host_rd && !host_addr) obf_d = 1'b0;

    if (wr_acc) begin
      hold_d = host_wdata;
      hcmd_d = host_addr;
      cd_d   = host_addr;
      ibf_d  = 1'b1;
      pend_d = 1'b1;
    end

    unique case (ph_q)
      PH_HOST: if (pend_q) begin
        pend_d = 1'b0;
        ibf_d  = 1'b0;
        if (hcmd_q && hold_q == OP_ABORT) begin
          if (st_q != KS_ERROR) begin
            tag_d = tag_q + 1'b1;
            rs_we = 1'b1; rs_wdata = EC_ABORTED;
            olen_d = CW'(1); opos_d = '0;
            st_d = KS_ERROR;
            obf_set = 1'b1;
          end
        end else begin
          unique case (st_q)
            KS_IDLE: if (hcmd_q) begin
              if (hold_q == OP_WSTART) begin
                st_d = KS_WRITE; icnt_d = '0; wend_d = 1'b0; obf_set = 1'b1;
              end else begin
                rs_we = 1'b1; olen_d = CW'(1); opos_d = '0; st_d = KS_ERROR;
              end
            end
            KS_WRITE: begin
              if (!hcmd_q) begin
                rq_we  = (icnt_q < CAP_L);
                icnt_d = (icnt_q == LEN_MAX) ? icnt_q : icnt_q + 1'b1;
                if (wend_q) begin
                  ph_d = PH_SEND; sidx_d = '0; ibf_d = 1'b1; wend_d = 1'b0;
                end else begin
                  obf_set = 1'b1;
                end
              end else if (hold_q == OP_WEND && !wend_q) begin
                wend_d = 1'b1; obf_set = 1'b1;
              end else begin
                rs_we = 1'b1; olen_d = CW'(1); opos_d = '0; st_d = KS_ERROR;
                obf_set = 1'b1;
              end
            end
            KS_READ: begin
              if (!hcmd_q && hold_q == OP_RDNEXT) begin
                obf_set = 1'b1;
                if (opos_q >= olen_q) begin
                  st_d = KS_IDLE;
                end else begin
                  dout_d = rs_rdata; opos_d = opos_q + 1'b1;
                end
              end else begin
                rs_we = 1'b1; olen_d = CW'(1); opos_d = '0; st_d = KS_ERROR;
                obf_set = 1'b1;
              end
            end
            default: begin
              if (!hcmd_q) begin
                obf_set = 1'b1;
                if (opos_q >= olen_q) begin
                  st_d = KS_IDLE;
                end else begin
                  st_d = KS_READ; dout_d = rs_rdata; opos_d = opos_q + 1'b1;
                end
              end else begin
                rs_we = 1'b1; olen_d = CW'(1); opos_d = '0; st_d = KS_ERROR;
              end
            end
          endcase
        end
      end
      PH_SEND: if (req_ready) begin
        if (req_last) begin
          ph_d = PH_WAIT; opos_d = '0; rcnt_d = '0;
        end else begin
          sidx_d = sidx_q + 1'b1;
        end
      end
      PH_WAIT: if (rsp_valid && rsp_tag == tag_q) begin
        if (rcnt_q < CAP_L) begin
          rs_we = 1'b1; rs_waddr = rcnt_q[AW-1:0]; rs_wdata = rsp_data;
        end
        rcnt_d = (rcnt_q == LEN_MAX) ? rcnt_q : rcnt_q + 1'b1;
        if (rsp_last) begin
          ph_d = PH_COMMIT;
          if (rtotal > (LEN_W+1)'(CAP)) begin
            olen_d = CW'(3);
            rs_we = 1'b1; rs_waddr = AW'(2); rs_wdata = TRUNC_CC;
          end else begin
            olen_d = CW'(rtotal);
          end
        end
      end
      default: begin
        tag_d = tag_q + 1'b1;
        st_d = KS_READ;
        dout_d = rs_rdata;
        opos_d = CW'(1);
        obf_set = 1'b1;
        ibf_d = 1'b0;
        ph_d = PH_HOST;
      end
    endcase

    if (obf_set) obf_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= KS_IDLE; ph_q <= PH_HOST;
      obf_q <= 1'b0; ibf_q <= 1'b0; cd_q <= 1'b0; atn_q <= 1'b0;
      pend_q <= 1'b0; hcmd_q <= 1'b0; wend_q <= 1'b0;
      hold_q <= '0; dout_q <= '0; icnt_q <= '0; rcnt_q <= '0;
      olen_q <= '0; opos_q <= '0; sidx_q <= '0; tag_q <= '0;
    end else begin
      st_q <= st_d; ph_q <= ph_d;
      obf_q <= obf_d; ibf_q <= ibf_d; cd_q <= cd_d; atn_q <= atn_d;
      pend_q <= pend_d; hcmd_q <= hcmd_d; wend_q <= wend_d;
      hold_q <= hold_d; dout_q <= dout_d; icnt_q <= icnt_d; rcnt_q <= rcnt_d;
      olen_q <= olen_d; opos_q <= opos_d; sidx_q <= sidx_d; tag_q <= tag_d;
    end
  end
endmodule

// File: rtl/kcs_host_if_chk.sv
module kcs_host_if_chk #(
  parameter int TAG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_wr,
  input logic             host_rd,
  input logic             host_addr,
  input logic             irq_en,
  input logic             irq,
  input logic             req_valid,
  input logic             req_ready,
  input logic [7:0]       req_data,
  input logic             req_last,
  input logic [TAG_W-1:0] req_tag,
  input logic [7:0]       status,
  input logic             obf_set
);
  // R6: a stalled request beat holds its contents
  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_data) &&
                                $stable(req_last) && $stable(req_tag));

  // R6: request beats only leave while in write state with input-full held
  p_req_in_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (status[7:6] == 2'd2) && status[1]);

  // R3: an accepted write raises input-full
  p_ibf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && !status[1] |=> status[1]);

  // R3: a write while input-full is set leaves the command/data bit alone
  p_wr_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && status[1] |=> $stable(status[3]));

  // R14: a data read clears output-full unless set in the same cycle
  p_obf_clear_r14: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && !host_addr && !obf_set |=> !status[0]);

  // R13: the interrupt can only rise after an enabled event
  p_irq_enable_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(irq_en));
endmodule

bind kcs_host_if kcs_host_if_chk #(.TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
  .host_addr(host_addr), .irq_en(irq_en), .irq(irq),
  .req_valid(req_valid), .req_ready(req_ready), .req_data(req_data),
  .req_last(req_last), .req_tag(req_tag), .status(status_w),
  .obf_set(obf_set)
);

// File: tb/tb_kcs_host_if.sv
`timescale 1ns/1ps
module tb_kcs_host_if;
  localparam int CAP = 8;
  localparam int TAG_W = 8;
  localparam int LEN_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_wr = 0, host_rd = 0, host_addr = 0;
  logic [7:0] host_wdata = 0, host_rdata;
  logic irq_en = 0, attn_set = 0, attn_clr = 0, irq;
  logic req_valid, req_ready = 0, req_last;
  logic [7:0] req_data;
  logic [TAG_W-1:0] req_tag;
  logic [LEN_W-1:0] req_len;
  logic rsp_valid = 0, rsp_ready, rsp_last = 0;
  logic [7:0] rsp_data = 0;
  logic [TAG_W-1:0] rsp_tag = 0;

  int n_chk = 0, n_bad = 0;
  int exp_tag = 0;
  logic [7:0] reqb [64];
  logic [7:0] rspb [64];

  always #2.5 clk = ~clk;

  kcs_host_if #(.CAP(CAP), .TAG_W(TAG_W), .LEN_W(LEN_W)) dut (.*);

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] stv(int s, bit obf, bit ibf, bit atn, bit cd);
    return {s[1:0], 2'b00, cd, atn, ibf, obf};
  endfunction

  function automatic int exp_rlen(int len);
    return (len > CAP) ? 3 : len;
  endfunction

  function automatic logic [7:0] exp_rbyte(int len, int k);
    if (len > CAP && k == 2) return 8'hCA;
    return rspb[k];
  endfunction

  task automatic hw(bit a, logic [7:0] v);
    @(negedge clk); host_wr = 1; host_addr = a; host_wdata = v;
    @(negedge clk); host_wr = 0;
    @(negedge clk);
  endtask

  task automatic hr(bit a, output logic [7:0] v);
    @(negedge clk); host_rd = 1; host_addr = a; #1 v = host_rdata;
    @(negedge clk); host_rd = 0;
  endtask

  task automatic stat_is(string req, logic [7:0] e);
    logic [7:0] v;
    hr(1, v);
    chk(req, v, e);
  endtask

  task automatic write_req(int n);
    logic [7:0] v;
    hw(1, 8'h61);
    stat_is("R5 write-start status", stv(2, 1, 0, 0, 1));
    hr(0, v);
    for (int i = 0; i < n - 1; i++) begin
      hw(0, reqb[i]);
      hr(0, v);
    end
    hw(1, 8'h62);
    hr(0, v);
    hw(0, reqb[n-1]);
    stat_is("R6 final byte holds input-full", stv(2, 0, 1, 0, 0));
  endtask

  task automatic get_req(int n);
    int got = 0;
    int lim = (n < CAP) ? n : CAP;
    int guard = 0;
    while (got < lim && guard < 1000) begin
      @(negedge clk); req_ready = ($urandom % 3) != 0; #1;
      guard++;
      if (req_valid && req_ready) begin
        chk("R6 request byte", req_data, reqb[got]);
        chk("R6 request last", req_last, got == lim - 1);
        chk("R6 request tag", req_tag, exp_tag % 256);
        if (got == 0) chk("R5 request length", req_len, (n > 255) ? 255 : n);
        got++;
      end
    end
    chk("R6 request beat count", got, lim);
    @(negedge clk); req_ready = 0; #1;
    chk("R6 request stream ends", req_valid, 0);
  endtask

  task automatic put_rsp(int tag, int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rsp_valid = 1; rsp_tag = tag[TAG_W-1:0]; rsp_data = rspb[i];
      rsp_last = (i == len - 1);
      #1 chk("R7 reply ready", rsp_ready, 1);
    end
    @(negedge clk); rsp_valid = 0; rsp_last = 0;
    @(negedge clk);
  endtask

  task automatic read_rsp(int len);
    logic [7:0] v;
    int el = exp_rlen(len);
    stat_is("R7 read state after reply", stv(1, 1, 0, 0, 0));
    for (int k = 0; k < el; k++) begin
      hr(0, v);
      chk(k == 2 && len > CAP ? "R8 truncation code" : "R9 reply byte", v, exp_rbyte(len, k));
      hw(0, 8'h68);
    end
    stat_is("R9 idle after last byte", stv(0, 1, 0, 0, 0));
    hr(0, v);
  endtask

  task automatic err_to_idle(logic [7:0] code, string req);
    logic [7:0] v;
    hr(0, v);
    hw(0, 8'h00);
    stat_is("R10 error data write enters read", stv(1, 1, 0, 0, 0));
    hr(0, v);
    chk(req, v, code);
    hw(0, 8'h68);
    stat_is("R9 idle after error byte", stv(0, 1, 0, 0, 0));
    hr(0, v);
  endtask

  task automatic transaction(int n, int len, bit stale);
    for (int i = 0; i < 64; i++) begin
      reqb[i] = 8'($urandom); rspb[i] = 8'($urandom);
    end
    write_req(n);
    get_req(n);
    if (stale) begin
      put_rsp(exp_tag + 1, 2);
      stat_is("R7 stale reply dropped", stv(2, 0, 1, 0, 0));
    end
    put_rsp(exp_tag, len);
    exp_tag++;
    read_rsp(len);
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset irq", irq, 0);
    chk("R1 reset req_valid", req_valid, 0);
    stat_is("R1 reset status", 8'h00);

    // R2/R9 basic transaction, R3 ignored write while waiting
    for (int i = 0; i < 64; i++) begin
      reqb[i] = 8'($urandom); rspb[i] = 8'($urandom);
    end
    write_req(3);
    get_req(3);
    hw(1, 8'h60);
    stat_is("R3 write ignored while input-full", stv(2, 0, 1, 0, 0));
    put_rsp(exp_tag + 5, 1);
    stat_is("R7 wrong tag dropped", stv(2, 0, 1, 0, 0));
    put_rsp(exp_tag, 4);
    exp_tag++;
    read_rsp(4);

    // R4 command/data bit and R3 input-full clear
    hw(0, 8'h33);
    stat_is("R4 data write clears cd, R3 ibf cleared", stv(0, 0, 0, 0, 0));

    // R5 request overflow, R8 overlong reply
    transaction(CAP + 3, 2, 0);
    transaction(2, CAP + 2, 1);
    transaction(CAP, CAP, 0);

    // R11 abort in write state
    hw(1, 8'h61); hr(0, v);
    hw(0, 8'h11); hr(0, v);
    hw(1, 8'h60);
    exp_tag++;
    stat_is("R11 abort enters error", stv(3, 1, 0, 0, 1));
    err_to_idle(8'h01, "R11 aborted code");

    // R11 abort in error state has no effect
    hw(1, 8'h60);
    exp_tag++;
    hr(0, v);
    hw(1, 8'h60);
    stat_is("R11 abort in error ignored", stv(3, 0, 0, 0, 1));
    err_to_idle(8'h01, "R11 code kept after second abort");

    // R12 bad command in idle
    hw(1, 8'h68);
    stat_is("R12 bad command in idle", stv(3, 0, 0, 0, 1));
    err_to_idle(8'h02, "R12 bad command code");

    // R12 bad command in write
    hw(1, 8'h61); hr(0, v);
    hw(1, 8'h61);
    stat_is("R12 bad command in write", stv(3, 1, 0, 0, 1));
    err_to_idle(8'h02, "R12 bad command code in write");

    // R10 bad handshake byte in read state
    for (int i = 0; i < 64; i++) rspb[i] = 8'($urandom);
    reqb[0] = 8'h5A;
    write_req(1);
    get_req(1);
    put_rsp(exp_tag, 3);
    exp_tag++;
    hr(0, v);
    chk("R7 first reply byte", v, rspb[0]);
    hw(0, 8'h55);
    stat_is("R10 bad read byte enters error", stv(3, 1, 0, 0, 0));
    err_to_idle(8'h02, "R10 error byte");

    // R13 interrupt behaviour, R14 obf clear
    irq_en = 1;
    hw(1, 8'h61);
    chk("R13 irq on output-full", irq, 1);
    hr(0, v);
    chk("R13 irq drops on data read", irq, 0);
    stat_is("R14 data read clears obf", stv(2, 0, 0, 0, 1));
    @(negedge clk); attn_set = 1;
    @(negedge clk); attn_set = 0;
    chk("R13 irq on attention", irq, 1);
    hr(1, v);
    chk("R13 status shows attention", v[2], 1);
    chk("R13 status read clears attention irq", irq, 0);
    stat_is("R13 attention bit stays", stv(2, 0, 0, 1, 1));
    @(negedge clk); attn_clr = 1;
    @(negedge clk); attn_clr = 0;
    stat_is("R13 attention cleared", stv(2, 0, 0, 0, 1));
    irq_en = 0;
    hw(1, 8'h60);
    exp_tag++;
    chk("R13 no irq while disabled", irq, 0);
    err_to_idle(8'h01, "R11 abort code after irq test");
    chk("R13 irq stays low", irq, 0);

    // random transactions
    for (int t = 0; t < 14; t++) begin
      transaction(1 + ($urandom % (CAP + 3)), 1 + ($urandom % (CAP + 3)), $urandom % 2);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule